// File: doc/BRIEF.md
# Multi-CPU Interrupt Enable and Acknowledge Unit

This block gathers level-type interrupt sources and presents them to up to four CPUs. The lower sources (0 through 28 by default) are banked: every CPU has its own copy of the level input and its own mask bit. Such a source reaches a CPU only while that CPU has it unmasked. The remaining sources are shared. Each shared source has one global enable bit and a routing field with one bit per CPU. Inputs 0 and 1 are meant to carry the summaries of the inbound IPI and MSI doorbells, and the block treats them like any other banked source.

Software never writes bitmaps for enable or mask state. It writes a source number to a set register or to a clear register, so a single store changes exactly one bit. Each CPU reads its acknowledge register to get the lowest-numbered source that currently qualifies for it, or 1023 when none does. One interrupt line per CPU is high whenever that CPU would read a value other than 1023.

Register access uses a valid/ready request channel and a valid/ready read-response channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A read places its data on the response channel on the next edge, and the data stays there until `rsp_ready` takes it. `req_ready` falls while an untaken response is held, which is the back-pressure path. A write takes effect on the edge that accepts it and produces no response.

Top module: `irq_fanout_ctl`

## Requirements
- R1: After reset every global enable is clear, every per-CPU mask bit is set and every routing field is zero. All `irq_o` lines are low and every acknowledge read returns 1023.
- R2: A read of global offset 0x000 returns the number of implemented sources in bits [11:2] and zero in every other bit.
- R3: Writing source number n (write data bits [9:0]) to global offset 0x030 sets the enable of shared source n, and writing it to 0x034 clears that enable. A number of 28 or below, or a number at or above the source count, changes nothing.
- R4: Writing source number n to offset 0x048 of the per-CPU bank (`req_bank`=1) masks banked source n for the CPU given on `req_cpu`, and writing it to 0x04C unmasks it. Other CPUs' masks are untouched. A number above 28 changes nothing.
- R5: The routing field of source n sits at global offset 0x100+4n. Bits [NUM_CPUS-1:0] are readable and writable, bit c routes to CPU c, and all other bits read as zero.
- R6: Banked source n (0 to 28) qualifies for CPU c exactly when `pc_level_i[c*29+n]` is high and n is unmasked for c. The enable and routing fields do not affect it.
- R7: Shared source n qualifies for CPU c exactly when `glb_level_i[n-29]` is high, its enable is set and routing bit c is set.
- R8: A read of bank offset 0x044 returns, in bits [9:0], the lowest-numbered source qualifying for the requesting CPU, or 1023 if there is none. The upper bits read as zero, and the read leaves all state unchanged.
- R9: `irq_o[c]` is high in exactly those cycles in which at least one source qualifies for CPU c.
- R10: A read accepted on an edge raises `rsp_valid` on that edge. `rsp_valid` and `rsp_rdata` then hold until an edge with `rsp_ready` high, and `req_ready` is low while an untaken response is held.
- R11: A read of an offset that is not listed above returns zero, and a write to such an offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 1 | 0 = global window, 1 = per-CPU window |
| req_cpu | input | 2 | Index of the CPU issuing the request |
| req_addr | input | ADDR_W | Byte offset within the window |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Read data taken |
| rsp_rdata | output | DATA_W | Read data |
| pc_level_i | input | NUM_CPUS*29 | Banked source levels, bit c*29+n |
| glb_level_i | input | NUM_SRC-29 | Shared source levels, bit n-29 |
| irq_o | output | NUM_CPUS | Interrupt request, one per CPU |

## Verification
The qualification logic is exercised with a banked source raised for one CPU only, which shows whether masks are really kept apart per CPU. A shared source is then walked through the enable, routing and clear steps, so that each of the three gates is seen to matter on its own. Several sources are made to qualify together, a banked one and a shared one among them, to confirm that the lowest number wins and that a repeated acknowledge read returns the same value. Cross-kind writes (an enable write to a banked number, a mask write to a shared number) check that the set/clear index decode does not reach the wrong storage.

// File: rtl/irq_fanout_pkg.sv
package irq_fanout_pkg;
  localparam int IDX_W = 10;
  localparam logic [IDX_W-1:0] IDLE_CODE = 10'd1023;

  localparam logic [11:0] OFS_CTRL     = 12'h000;
  localparam logic [11:0] OFS_EN_SET   = 12'h030;
  localparam logic [11:0] OFS_EN_CLR   = 12'h034;
  localparam logic [11:0] OFS_ACK      = 12'h044;
  localparam logic [11:0] OFS_MSK_SET  = 12'h048;
  localparam logic [11:0] OFS_MSK_CLR  = 12'h04C;
  localparam logic [11:0] OFS_RT_BASE  = 12'h100;

  typedef enum logic [1:0] {
    RSEL_ZERO,
    RSEL_CTRL,
    RSEL_ROUTE,
    RSEL_ACK
  } rsel_e;

  typedef struct packed {
    logic             en_set;
    logic             en_clr;
    logic             msk_set;
    logic             msk_clr;
    logic             rt_wr;
    logic [IDX_W-1:0] idx;
    logic [1:0]       cpu;
    logic [3:0]       rt_val;
  } reg_cmd_t;
endpackage

// File: rtl/irq_regport.sv
module irq_regport
  import irq_fanout_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_bank,
  input  logic [1:0]        req_cpu,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output reg_cmd_t          cmd,
  output rsel_e             rsel,
  input  logic [DATA_W-1:0] rd_data
);
  logic              take;
  logic              is_wr;
  logic              is_rd;
  logic [ADDR_W-1:0] rt_rel;
  logic              rt_hit;
  logic [IDX_W-1:0]  rt_idx;

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;
  assign is_wr     = take && req_write;
  assign is_rd     = take && !req_write;

  assign rt_rel = req_addr - ADDR_W'(OFS_RT_BASE);
  assign rt_idx = rt_rel[IDX_W+1:2];
  assign rt_hit = !req_bank && (req_addr >= ADDR_W'(OFS_RT_BASE)) &&
                  (req_addr[1:0] == 2'b00) &&
                  (int'(rt_rel >> 2) < NUM_SRC);

  always_comb begin
    cmd         = '0;
    cmd.cpu     = req_cpu;
    cmd.rt_val  = req_wdata[3:0];
    cmd.idx     = rt_hit ? rt_idx : req_wdata[IDX_W-1:0];
    rsel        = RSEL_ZERO;
    if (is_wr) begin
      if (!req_bank) begin
        cmd.en_set = (req_addr == ADDR_W'(OFS_EN_SET));
        cmd.en_clr = (req_addr == ADDR_W'(OFS_EN_CLR));
        cmd.rt_wr  = rt_hit;
      end else begin
        cmd.msk_set = (req_addr == ADDR_W'(OFS_MSK_SET));
        cmd.msk_clr = (req_addr == ADDR_W'(OFS_MSK_CLR));
      end
    end
    if (!req_bank) begin
      if (req_addr == ADDR_W'(OFS_CTRL)) rsel = RSEL_CTRL;
      else if (rt_hit)                   rsel = RSEL_ROUTE;
    end else if (req_addr == ADDR_W'(OFS_ACK)) begin
      rsel = RSEL_ACK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (is_rd) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |=> rsp_valid); // R10
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R10
endmodule

// File: rtl/irq_src_state.sv
module irq_src_state
  import irq_fanout_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int NUM_CPUS = 4,
  parameter int NUM_PC   = 29
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  reg_cmd_t                             cmd,
  output logic [NUM_SRC-1:0]                   en_q,
  output logic [NUM_CPUS-1:0][NUM_PC-1:0]      mask_q,
  output logic [NUM_SRC-1:0][NUM_CPUS-1:0]     route_q
);
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    logic hit;
    assign hit = (cmd.idx == IDX_W'(n));

    if (n < NUM_PC) begin : g_banked
      assign en_q[n] = 1'b0;
    end else begin : g_shared
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    en_q[n] <= 1'b0;
        else if (cmd.en_set && hit)    en_q[n] <= 1'b1;
        else if (cmd.en_clr && hit)    en_q[n] <= 1'b0;
      end
      AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.en_set && hit) |=> en_q[n]); // R3
      AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.en_clr && hit && !cmd.en_set) |=> !en_q[n]); // R3
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 route_q[n] <= '0;
      else if (cmd.rt_wr && hit)  route_q[n] <= cmd.rt_val[NUM_CPUS-1:0];
    end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar n = 0; n < NUM_PC; n++) begin : g_bit
      logic mine;
      assign mine = (cmd.cpu == 2'(c)) && (cmd.idx == IDX_W'(n));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    mask_q[c][n] <= 1'b1;
        else if (cmd.msk_set && mine)  mask_q[c][n] <= 1'b1;
        else if (cmd.msk_clr && mine)  mask_q[c][n] <= 1'b0;
      end
      AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.msk_set && mine) |=> mask_q[c][n]); // R4
      AST_MASK_OTHER_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.cpu != 2'(c)) |=> $stable(mask_q[c][n])); // R4
    end
  end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick
  import irq_fanout_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   qual,
  output logic                 any,
  output logic [IDX_W-1:0]     idx
);
  always_comb begin
    idx = IDLE_CODE;
    for (int n = NUM_SRC - 1; n >= 0; n--) begin
      if (qual[n]) idx = IDX_W'(n);
    end
  end
  assign any = |qual;

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_chk
    AST_ACK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (idx == IDX_W'(n)) |-> qual[n]); // R8
    AST_ACK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      qual[n] |-> (idx <= IDX_W'(n))); // R8
  end
  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (qual == '0) |-> (idx == IDLE_CODE)); // R8
endmodule

// File: rtl/irq_fanout_ctl.sv
module irq_fanout_ctl
  import irq_fanout_pkg::*;
#(
  parameter int NUM_CPUS  = 4,
  parameter int NUM_SRC   = 64,
  parameter int PCPU_LAST = 28,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_write,
  input  logic                            req_bank,
  input  logic [1:0]                      req_cpu,
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic [DATA_W-1:0]               req_wdata,
  output logic                            rsp_valid,
  input  logic                            rsp_ready,
  output logic [DATA_W-1:0]               rsp_rdata,
  input  logic [NUM_CPUS*(PCPU_LAST+1)-1:0] pc_level_i,
  input  logic [NUM_SRC-PCPU_LAST-2:0]    glb_level_i,
  output logic [NUM_CPUS-1:0]             irq_o
);
  localparam int NUM_PC  = PCPU_LAST + 1;
  localparam int NUM_GLB = NUM_SRC - NUM_PC;

  reg_cmd_t                              cmd;
  rsel_e                                 rsel;
  logic [DATA_W-1:0]                     rd_data;
  logic [NUM_SRC-1:0]                    en_q;
  logic [NUM_CPUS-1:0][NUM_PC-1:0]       mask_q;
  logic [NUM_SRC-1:0][NUM_CPUS-1:0]      route_q;
  logic [NUM_CPUS-1:0][NUM_SRC-1:0]      qual;
  logic [NUM_CPUS-1:0][IDX_W-1:0]        ack;

  irq_regport #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_cpu(req_cpu), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .cmd(cmd), .rsel(rsel), .rd_data(rd_data)
  );

  irq_src_state #(.NUM_SRC(NUM_SRC), .NUM_CPUS(NUM_CPUS), .NUM_PC(NUM_PC)) u_state (
    .clk(clk), .rst_n(rst_n), .cmd(cmd),
    .en_q(en_q), .mask_q(mask_q), .route_q(route_q)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_q
      if (n < NUM_PC) begin : g_banked
        assign qual[c][n] = pc_level_i[c*NUM_PC+n] && !mask_q[c][n];
      end else begin : g_shared
        assign qual[c][n] = glb_level_i[n-NUM_PC] && en_q[n] && route_q[n][c];
      end
    end
    irq_lowest_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .clk(clk), .rst_n(rst_n), .qual(qual[c]),
      .any(irq_o[c]), .idx(ack[c])
    );
  end

  always_comb begin
    logic [IDX_W-1:0]    ack_sel;
    logic [NUM_CPUS-1:0] rt_sel;
    ack_sel = IDLE_CODE;
    rt_sel  = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      if (cmd.cpu == 2'(c)) ack_sel = ack[c];
    end
    for (int n = 0; n < NUM_SRC; n++) begin
      if (cmd.idx == IDX_W'(n)) rt_sel = route_q[n];
    end
    rd_data = '0;
    case (rsel)
      RSEL_CTRL:  rd_data = DATA_W'({IDX_W'(NUM_SRC), 2'b00});
      RSEL_ROUTE: rd_data = DATA_W'(rt_sel);
      RSEL_ACK:   rd_data = DATA_W'(ack_sel);
      default:    rd_data = '0;
    endcase
  end

  if (NUM_GLB < 1 || NUM_CPUS > 4 || ADDR_W < 12) begin : g_bad_cfg
    initial $error("irq_fanout_ctl: unsupported parameter set");
  end
endmodule

// File: tb/tb_irq_fanout_ctl.sv
`timescale 1ns/1ps
module tb_irq_fanout_ctl;
  localparam int NC = 4;
  localparam int NS = 64;
  localparam int NP = 29;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_write = 0, req_bank = 0, rsp_ready = 1;
  logic [1:0]  req_cpu = 0;
  logic [11:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NC*NP-1:0] pc_lvl = '0;
  logic [NS-NP-1:0] glb_lvl = '0;
  logic [NC-1:0]    irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  irq_fanout_ctl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_cpu(req_cpu),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .pc_level_i(pc_lvl),
    .glb_level_i(glb_lvl), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic bank, input logic [1:0] cpu, input logic [11:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_bank = bank; req_cpu = cpu; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic bank, input logic [1:0] cpu, input logic [11:0] a, output logic [31:0] d);
    req_valid = 1; req_write = 0; req_bank = bank; req_cpu = cpu; req_addr = a;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    d = rsp_valid ? rsp_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic ack_is(input logic [1:0] cpu, input logic [31:0] exp, input string req);
    logic [31:0] d;
    rd(1, cpu, 12'h044, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    #1 check("R1 irq_o after reset", 32'(irq_o), 0);
    for (int c = 0; c < NC; c++) ack_is(2'(c), 1023, "R1 ack after reset");
    rd(0, 0, 12'h100 + 12'd4*12'd40, d);
    check("R1 route zero after reset", d, 0);
    pc_lvl[1*NP+9] = 1;
    #1 check("R1 masked banked level", 32'(irq_o), 0);
    pc_lvl[1*NP+9] = 0;
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    rd(0, 2, 12'h000, d);
    check("R2 source count field", d, 32'(NS) << 2);
  endtask

  task automatic t_banked;
    pc_lvl[1*NP+5] = 1;
    wr(1, 0, 12'h04C, 5);
    #1 check("R4 unmask by cpu0 leaves cpu1 masked", 32'(irq_o), 0);
    wr(1, 1, 12'h04C, 5);
    #1 check("R6 R9 banked src for cpu1", 32'(irq_o), 32'b0010);
    ack_is(1, 5, "R8 cpu1 ack banked");
    ack_is(0, 1023, "R6 cpu0 not pending");
    wr(1, 1, 12'h048, 5);
    #1 check("R4 mask again", 32'(irq_o), 0);
  endtask

  task automatic t_cross_kind;
    pc_lvl[2*NP+3] = 1;
    wr(0, 0, 12'h030, 3);
    wr(0, 0, 12'h100 + 12'd12, 32'hF);
    #1 check("R3 R6 enable/route ignored for banked", 32'(irq_o), 0);
    pc_lvl[2*NP+3] = 0;
  endtask

  task automatic t_shared;
    glb_lvl[40-NP] = 1;
    wr(0, 0, 12'h030, 40);
    #1 check("R7 enabled but unrouted", 32'(irq_o), 0);
    wr(0, 0, 12'h100 + 12'd160, 32'h9);
    #1 check("R7 R9 routed to cpu0 and cpu3", 32'(irq_o), 32'b1001);
    ack_is(3, 40, "R8 cpu3 ack shared");
    wr(0, 0, 12'h034, 40);
    #1 check("R3 enable cleared", 32'(irq_o), 0);
    wr(0, 0, 12'h030, 40);
    wr(1, 0, 12'h048, 40);
    #1 check("R4 mask write of shared number ignored", 32'(irq_o), 32'b1001);
  endtask

  task automatic t_lowest;
    pc_lvl[0*NP+2] = 1;
    pc_lvl[0*NP+7] = 1;
    wr(1, 0, 12'h04C, 7);
    ack_is(0, 7, "R8 banked below shared");
    wr(1, 0, 12'h04C, 2);
    ack_is(0, 2, "R8 lowest of three");
    ack_is(0, 2, "R8 repeat read no side effect");
    pc_lvl[0*NP+2] = 0;
    ack_is(0, 7, "R8 next lowest after drop");
    glb_lvl[40-NP] = 0;
    pc_lvl[0*NP+7] = 0;
    #1 check("R9 all lines low", 32'(irq_o), 0);
  endtask

  task automatic t_route_rw;
    logic [31:0] d;
    wr(0, 0, 12'h100 + 12'd200, 32'hFFFF_FFFF);
    rd(0, 0, 12'h100 + 12'd200, d);
    check("R5 route field width", d, 32'hF);
  endtask

  task automatic t_undefined;
    logic [31:0] d;
    rd(0, 0, 12'h010, d);
    check("R11 undefined global read", d, 0);
    rd(1, 0, 12'h048, d);
    check("R11 write-only bank read", d, 0);
    wr(0, 0, 12'h038, 32'hFFFF_FFFF);
    rd(0, 0, 12'h100 + 12'd200, d);
    check("R11 stray write no effect", d, 32'hF);
  endtask

  task automatic t_handshake;
    logic [31:0] d;
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_bank = 0; req_addr = 12'h000;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    check("R10 rsp_valid raised", 32'(rsp_valid), 1);
    check("R10 req_ready low while held", 32'(req_ready), 0);
    d = rsp_rdata;
    @(posedge clk); @(negedge clk);
    check("R10 rsp held", 32'(rsp_valid), 1);
    check("R10 data stable", rsp_rdata, d);
    rsp_ready = 1;
    @(posedge clk); @(negedge clk);
    check("R10 rsp taken", 32'(rsp_valid), 0);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_banked();
    t_cross_kind();
    t_shared();
    t_lowest();
    t_route_rw();
    t_undefined();
    t_handshake();
    done = 1;
    finish_run();
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule